// File: doc/BRIEF.md
# Asynchronous HDLC Transmit Framer

This block sits between a packet source and a byte-wide 8N1 UART serializer and produces the octet-oriented HDLC character stream used by PPP-style serial links. Payload bytes arrive on a valid/ready interface, with a marker on the final byte of each frame. The block wraps each frame in flag characters. It escapes characters that must not appear literally on the line, and it appends a 16-bit frame check sequence. Characters leave on a second valid/ready interface, and an idle indication tells the serializer to hold the line at the all-ones level.

A 32-bit map selects which of the control characters 0x00 to 0x1F are escaped, so a link can protect only the control codes its far end cannot pass. A stop command cuts the running frame short, sends a two-character abort, and then keeps the line idle until a restart command arrives. An optional flow-control mode pauses the character stream on clear-to-send without losing its place.

Top module: `ahdlc_tx_framer`

## Requirements
- R1: While reset is held and right after it is released, out_valid is 0, out_idle is 1 and in_ready is 0.
- R2: Each frame is sent as 0x7E, then the encoded payload, then the encoded check bytes, then 0x7E. The opening flag is emitted before the first payload byte is accepted. A last marker on the first byte gives a one-byte frame.
- R3: A byte is escaped when it equals 0x7E or 0x7D, or when its value n is below 32 and bit n of ctl_map is 1. All other bytes pass unchanged.
- R4: An escaped byte b becomes the two characters 0x7D and b XOR 0x20, in that order.
- R5: The check uses the reflected CRC-CCITT polynomial 0x8408 with preset 0xFFFF, computed over the unescaped payload. It is sent ones-complemented, low byte first, with both bytes escaped under R3. Decoding a frame body and running the same CRC over payload and check bytes yields 0xF0B8.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_char stays unchanged. No character is dropped, repeated or reordered under backpressure.
- R7: out_idle is 1 exactly when out_valid is 0. Between frames out_valid is 0.
- R8: With flow_en at 1 and cts at 0, a character already presented on the output may still complete, and no new character is presented. When cts returns to 1, the stream resumes at the exact point where it paused.
- R9: With flow_en at 0, the cts input has no effect.
- R10: After a stop_cmd pulse, the character already presented completes and the rest of the frame is discarded, including any pending escape half and the check bytes. Next comes 0x7D then 0x7E, and after that out_valid and in_ready stay 0 until restart_cmd. A stop_cmd during the abort or the halt is ignored.
- R11: In a cycle where stop_cmd is 1, in_ready is 0, so a byte offered in that cycle is not consumed.
- R12: restart_cmd leaves the halted state. The next frame starts with an opening flag and a fresh 0xFFFF check preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is offered |
| in_last | input | 1 | Offered byte ends its frame |
| in_ready | output | 1 | Byte is accepted in this cycle when in_valid is 1 |
| ctl_map | input | MAP_W (32) | Bit n set: control character n is escaped |
| stop_cmd | input | 1 | One-cycle pulse: abort and halt |
| restart_cmd | input | 1 | One-cycle pulse: leave the halted state |
| flow_en | input | 1 | Enables pausing on cts |
| cts | input | 1 | Clear to send |
| out_char | output | 8 | Line character |
| out_valid | output | 1 | out_char is presented |
| out_ready | input | 1 | Serializer takes out_char |
| out_idle | output | 1 | Line should idle at all ones |

## Verification
The stop command can arrive in the same cycle that a payload byte would otherwise be accepted. It can also arrive while the second half of an escape is waiting in the pending register. The bench provokes the first case by raising stop_cmd in the very cycle it presents the final byte of a frame to a ready framer. It judges the result in three ways: in_ready must read 0 in that cycle, the line must carry exactly flag, first byte, 0x7D, 0x7E, and after restart the same byte must come out as a complete one-byte frame. For the second case, a stream of all-escaped bytes is stopped at an arbitrary point. The captured line must then be a clean prefix of escape pairs followed directly by the abort, with no stray pending character.

// File: rtl/ahdlc_tx_pkg.sv
`timescale 1ns/1ps
package ahdlc_tx_pkg;

  localparam int CHAR_W = 8;

  localparam logic [CHAR_W-1:0] FLAG_CHAR = 8'h7E;
  localparam logic [CHAR_W-1:0] ESC_CHAR  = 8'h7D;
  localparam logic [CHAR_W-1:0] ESC_FLIP  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_FCS_LO,
    ST_FCS_HI,
    ST_CLOSE,
    ST_ABT_ESC,
    ST_ABT_FLAG,
    ST_HALT
  } tx_state_e;

endpackage

// File: rtl/ahdlc_esc_check.sv
`timescale 1ns/1ps
// Decides whether one byte needs the two-character escape form (R3).
module ahdlc_esc_check #(
  parameter int MAP_W = 32
) (
  input  logic [7:0]       byte_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             need_esc
);
  import ahdlc_tx_pkg::*;

  localparam int IDX_W = (MAP_W > 1) ? $clog2(MAP_W) : 1;

  logic in_range;
  logic map_hit;

  always_comb begin
    in_range = ({1'b0, byte_i} < 9'(MAP_W));
    map_hit  = in_range && map_i[byte_i[IDX_W-1:0]];
    need_esc = (byte_i == FLAG_CHAR) || (byte_i == ESC_CHAR) || map_hit;
  end

endmodule

// File: rtl/ahdlc_fcs_calc.sv
`timescale 1ns/1ps
// Running reflected CRC over unescaped payload bytes (R5).
module ahdlc_fcs_calc #(
  parameter int              FCS_W    = 16,
  parameter logic [FCS_W-1:0] FCS_POLY = 16'h8408,
  parameter logic [FCS_W-1:0] FCS_INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             upd_i,
  input  logic [7:0]       byte_i,
  output logic [FCS_W-1:0] fcs_o
);

  logic [FCS_W-1:0] crc_q;

  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c,
                                                input logic [7:0] b);
    logic [FCS_W-1:0] r;
    r = c ^ {{(FCS_W-8){1'b0}}, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ FCS_POLY) : (r >> 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      crc_q <= FCS_INIT;
    end else if (upd_i) begin
      crc_q <= crc_step(crc_q, byte_i);
    end
  end

  assign fcs_o = ~crc_q;

endmodule

// File: rtl/ahdlc_out_reg.sv
`timescale 1ns/1ps
// Registered character output with valid/ready and idle flag (R6, R7).
module ahdlc_out_reg #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              out_ready,
  output logic              space_o,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_idle
);

  assign space_o = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idle  <= 1'b1;
      out_char  <= '1;
    end else if (load_i) begin
      out_valid <= 1'b1;
      out_idle  <= 1'b0;
      out_char  <= char_i;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_idle  <= 1'b1;
    end
  end

endmodule

// File: rtl/ahdlc_tx_framer.sv
`timescale 1ns/1ps
module ahdlc_tx_framer #(
  parameter int MAP_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  input  logic [MAP_W-1:0] ctl_map,
  input  logic             stop_cmd,
  input  logic             restart_cmd,
  input  logic             flow_en,
  input  logic             cts,
  output logic [7:0]       out_char,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_idle
);
  import ahdlc_tx_pkg::*;

  localparam int              FCS_W    = 16;
  localparam logic [FCS_W-1:0] FCS_POLY = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_INIT = 16'hFFFF;

  tx_state_e         state_q;
  logic              pend_v_q;
  logic [CHAR_W-1:0] pend_c_q;

  logic              space;
  logic              in_abort_grp;
  logic              stop_take;
  logic              flow_block;
  logic              slot;
  logic              have_char;
  logic              load;
  logic [CHAR_W-1:0] nxt_char;
  logic [CHAR_W-1:0] sel_byte;
  logic              need_esc;
  logic [FCS_W-1:0]  fcs;
  logic              take;

  // R10: abort and halt states ignore a further stop
  assign in_abort_grp = (state_q == ST_ABT_ESC) || (state_q == ST_ABT_FLAG) ||
                        (state_q == ST_HALT);
  assign stop_take    = stop_cmd && !in_abort_grp;
  // R8, R9: cts only matters when flow control is enabled
  assign flow_block   = flow_en && !cts;
  assign slot         = space && !flow_block && !stop_take;

  // R11: input is never accepted in a stop cycle
  assign in_ready = (state_q == ST_BODY) && !pend_v_q && slot;
  assign take     = in_valid && in_ready;

  always_comb begin
    unique case (state_q)
      ST_FCS_LO: sel_byte = fcs[7:0];
      ST_FCS_HI: sel_byte = fcs[15:8];
      default:   sel_byte = in_data;
    endcase
  end

  ahdlc_esc_check #(.MAP_W(MAP_W)) u_esc (
    .byte_i   (sel_byte),
    .map_i    (ctl_map),
    .need_esc (need_esc)
  );

  ahdlc_fcs_calc #(
    .FCS_W    (FCS_W),
    .FCS_POLY (FCS_POLY),
    .FCS_INIT (FCS_INIT)
  ) u_fcs (
    .clk    (clk),
    .rst    (rst),
    .init_i (state_q == ST_IDLE),
    .upd_i  (take),
    .byte_i (in_data),
    .fcs_o  (fcs)
  );

  always_comb begin
    have_char = 1'b0;
    nxt_char  = '1;
    if (pend_v_q) begin
      have_char = 1'b1;
      nxt_char  = pend_c_q;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          have_char = in_valid;
          nxt_char  = FLAG_CHAR;
        end
        ST_BODY: begin
          have_char = in_valid;
          nxt_char  = need_esc ? ESC_CHAR : sel_byte;
        end
        ST_FCS_LO, ST_FCS_HI: begin
          have_char = 1'b1;
          nxt_char  = need_esc ? ESC_CHAR : sel_byte;
        end
        ST_CLOSE, ST_ABT_FLAG: begin
          have_char = 1'b1;
          nxt_char  = FLAG_CHAR;
        end
        ST_ABT_ESC: begin
          have_char = 1'b1;
          nxt_char  = ESC_CHAR;
        end
        default: begin
          have_char = 1'b0;
          nxt_char  = '1;
        end
      endcase
    end
  end

  assign load = slot && have_char;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pend_v_q <= 1'b0;
      pend_c_q <= '0;
    end else if (stop_take) begin
      state_q  <= ST_ABT_ESC;
      pend_v_q <= 1'b0;
    end else if (state_q == ST_HALT) begin
      if (restart_cmd) begin
        state_q <= ST_IDLE;
      end
    end else if (load) begin
      if (pend_v_q) begin
        pend_v_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: state_q <= ST_BODY;
          ST_BODY, ST_FCS_LO, ST_FCS_HI: begin
            if (need_esc) begin
              pend_v_q <= 1'b1;
              pend_c_q <= sel_byte ^ ESC_FLIP;
            end
            if (state_q == ST_FCS_LO) begin
              state_q <= ST_FCS_HI;
            end else if (state_q == ST_FCS_HI) begin
              state_q <= ST_CLOSE;
            end else if (in_last) begin
              state_q <= ST_FCS_LO;
            end
          end
          ST_CLOSE:    state_q <= ST_IDLE;
          ST_ABT_ESC:  state_q <= ST_ABT_FLAG;
          ST_ABT_FLAG: state_q <= ST_HALT;
          default:     state_q <= state_q;
        endcase
      end
    end
  end

  ahdlc_out_reg #(.CHAR_W(CHAR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .char_i    (nxt_char),
    .out_ready (out_ready),
    .space_o   (space),
    .out_valid (out_valid),
    .out_char  (out_char),
    .out_idle  (out_idle)
  );

endmodule

// File: rtl/ahdlc_tx_framer_chk.sv
`timescale 1ns/1ps
module ahdlc_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       restart_cmd,
  input logic       flow_en,
  input logic       cts,
  input logic [7:0] out_char,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_idle
);

  logic acc;
  logic last_was_esc;
  logic aborted;

  assign acc = out_valid && out_ready;

  // Tracks an accepted 0x7D directly followed by an accepted 0x7E: the abort.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_was_esc <= 1'b0;
      aborted      <= 1'b0;
    end else begin
      if (acc) begin
        last_was_esc <= (out_char == 8'h7D);
      end
      if (restart_cmd) begin
        aborted <= 1'b0;
      end else if (acc && last_was_esc && out_char == 8'h7E) begin
        aborted <= 1'b1;
      end
    end
  end

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_char)); // R6

  AST_IDLE_TRACKS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_idle == !out_valid); // R7

  AST_FLOW_NO_NEW_CHAR: assert property (@(posedge clk) disable iff (rst)
    flow_en && !cts && !(out_valid && !out_ready) |=> !out_valid); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    aborted |-> !out_valid && !in_ready); // R10

endmodule

bind ahdlc_tx_framer ahdlc_tx_framer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .restart_cmd (restart_cmd),
  .flow_en     (flow_en),
  .cts         (cts),
  .out_char    (out_char),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_idle    (out_idle)
);

// File: tb/ahdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module ahdlc_tx_framer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [31:0] ctl_map = 32'h0;
  logic        stop_cmd = 1'b0;
  logic        restart_cmd = 1'b0;
  logic        flow_en = 1'b0;
  logic        cts = 1'b1;
  logic [7:0]  out_char;
  logic        out_valid;
  logic        out_idle;
  logic        out_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cap [0:1023];
  int cap_n = 0;
  logic [7:0] expc [0:1023];
  int exp_n = 0;
  logic [7:0] pay [0:511];
  logic rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  ahdlc_tx_framer u_ahdlc_tx_framer (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .ctl_map(ctl_map),
    .stop_cmd(stop_cmd), .restart_cmd(restart_cmd), .flow_en(flow_en),
    .cts(cts), .out_char(out_char), .out_valid(out_valid),
    .out_ready(out_ready), .out_idle(out_idle)
  );

  // Sink: ready changes just after a rising edge, capture just after a falling edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready && cap_n < 1024) begin
      cap[cap_n] = out_char;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic push(input logic [7:0] b);
    expc[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_enc(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D || (b < 8'h20 && ctl_map[b[4:0]])) begin
      push(8'h7D);
      push(b ^ 8'h20);
    end else begin
      push(b);
    end
  endtask

  task automatic build_exp(input int n);
    logic [15:0] c;
    logic [15:0] f;
    c = 16'hFFFF;
    exp_n = 0;
    push(8'h7E);
    for (int i = 0; i < n; i++) begin
      c = crc_byte(c, pay[i]);
      push_enc(pay[i]);
    end
    f = ~c;
    push_enc(f[7:0]);
    push_enc(f[15:8]);
    push(8'h7E);
  endtask

  task automatic wait_hs();
    bit hs;
    hs = 1'b0;
    while (!hs) begin
      @(negedge clk);
      #1;
      hs = in_ready;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = pay[i];
      in_last  = (i == n - 1);
      wait_hs();
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_done();
    int g;
    g = 0;
    while (!(cap_n >= exp_n && out_valid == 1'b0) && g < 5000) begin
      tick();
      g++;
    end
    repeat (3) tick();
  endtask

  task automatic compare_frame(input string req);
    int bad;
    logic [15:0] c;
    bit e;
    bad = -1;
    chk(cap_n == exp_n, req, "char count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && cap[i] != expc[i]) bad = i;
    chk(bad < 0, req, $sformatf("char at %0d", bad),
        (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expc[bad]));
    c = 16'hFFFF;
    e = 1'b0;
    for (int i = 1; i < cap_n - 1; i++) begin
      if (!e && cap[i] == 8'h7D) begin
        e = 1'b1;
      end else begin
        c = crc_byte(c, e ? (cap[i] ^ 8'h20) : cap[i]);
        e = 1'b0;
      end
    end
    chk(c == 16'hF0B8, "R5", "decoded check residue", c, 16'hF0B8);
  endtask

  task automatic run_frame(input int n, input string req);
    cap_n = 0;
    build_exp(n);
    send_frame(n);
    wait_done();
    compare_frame(req);
  endtask

  task automatic pulse_stop();
    stop_cmd = 1'b1;
    tick();
    stop_cmd = 1'b0;
  endtask

  task automatic pulse_restart();
    restart_cmd = 1'b1;
    tick();
    restart_cmd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int snap;
    int bad_cnt;
    bit pat_ok;

    repeat (4) tick();
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_idle == 1'b1, "R1", "out_idle in reset", out_idle, 1);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    tick();
    rst = 1'b0;
    tick();
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1", "quiet after reset",
        {out_valid, in_ready}, 0);

    // R2: one-byte frame
    pay[0] = 8'h41;
    run_frame(1, "R2");
    chk(out_idle == 1'b1 && out_valid == 1'b0, "R7", "idle between frames",
        {out_idle, out_valid}, 2);

    // R3 R4 R5 R6: every byte value under three maps with random backpressure
    rdy_rand = 1'b1;
    for (int m = 0; m < 3; m++) begin
      ctl_map = (m == 0) ? 32'h0 : (m == 1) ? 32'hFFFF_FFFF : 32'h5A0F_C381;
      for (int i = 0; i < 256; i++) pay[i] = 8'(i);
      run_frame(256, "R3 R4 R6");
    end
    rdy_rand = 1'b0;

    // R3: each map bit alone against all control characters
    for (int k = 0; k < 32; k++) begin
      ctl_map = 32'h1 << k;
      for (int i = 0; i < 32; i++) pay[i] = 8'(i);
      pay[32] = 8'h7E;
      pay[33] = 8'h7D;
      pay[34] = 8'h20;
      run_frame(35, "R3");
    end

    // R8: pause on cts with flow control enabled
    ctl_map = 32'h0000_00F0;
    flow_en = 1'b1;
    for (int i = 0; i < 60; i++) pay[i] = 8'(i * 7);
    cap_n = 0;
    build_exp(60);
    fork
      send_frame(60);
      begin
        repeat (12) tick();
        cts = 1'b0;
        repeat (3) tick();
        snap = cap_n;
        repeat (30) tick();
        chk(cap_n == snap, "R8", "chars sent while cts low", cap_n, snap);
        chk(out_valid == 1'b0, "R8", "out_valid while cts low", out_valid, 0);
        chk(out_idle == 1'b1, "R7", "idle while paused", out_idle, 1);
        cts = 1'b1;
      end
    join
    wait_done();
    compare_frame("R8");

    // R9: cts ignored without flow control
    flow_en = 1'b0;
    cts = 1'b0;
    for (int i = 0; i < 20; i++) pay[i] = 8'(8'h7A + i);
    run_frame(20, "R9");
    cts = 1'b1;

    // R10: stop during a stream of escaped bytes
    ctl_map = 32'h0;
    cap_n = 0;
    in_valid = 1'b1;
    in_data = 8'h7E;
    in_last = 1'b0;
    repeat (21) tick();
    pulse_stop();
    bad_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (in_ready !== 1'b0) bad_cnt++;
      tick();
    end
    chk(bad_cnt == 0, "R10", "in_ready cycles after stop", bad_cnt, 0);
    snap = cap_n;
    pulse_stop();
    repeat (10) tick();
    chk(cap_n == snap, "R10", "second stop while halted", cap_n, snap);
    chk(cap_n >= 3 && cap[cap_n-2] == 8'h7D && cap[cap_n-1] == 8'h7E, "R10",
        "abort tail", {cap[cap_n-2], cap[cap_n-1]}, 16'h7D7E);
    pat_ok = (cap[0] == 8'h7E);
    for (int k = 1; k < cap_n - 2; k++)
      if (cap[k] != (((k % 2) == 1) ? 8'h7D : 8'h5E)) pat_ok = 1'b0;
    chk(pat_ok, "R10", "prefix before abort", pat_ok, 1);
    chk(out_valid == 1'b0 && out_idle == 1'b1, "R10", "line idle when halted",
        {out_valid, out_idle}, 1);
    in_valid = 1'b0;

    // R12: restart, then a fresh frame
    pulse_restart();
    pay[0] = 8'h7E;
    run_frame(1, "R12");

    // R11: stop in the same cycle a byte is offered to a ready framer
    cap_n = 0;
    in_valid = 1'b1;
    in_data = 8'h5A;
    in_last = 1'b0;
    wait_hs();
    in_data = 8'h3C;
    in_last = 1'b1;
    stop_cmd = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R11", "in_ready in stop cycle", in_ready, 0);
    @(posedge clk);
    #1;
    stop_cmd = 1'b0;
    repeat (10) tick();
    chk(cap_n == 4, "R11", "chars around stop", cap_n, 4);
    chk(cap[0] == 8'h7E && cap[1] == 8'h5A && cap[2] == 8'h7D && cap[3] == 8'h7E,
        "R11", "line around stop", {cap[0], cap[1], cap[2], cap[3]}, 32'h7E5A7D7E);
    cap_n = 0;
    pulse_restart();
    wait_hs();
    in_valid = 1'b0;
    in_last = 1'b0;
    pay[0] = 8'h3C;
    build_exp(1);
    wait_done();
    compare_frame("R11 R12");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule